// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This block executes the one-bit instructions of a small controller. The carry flag serves as a one-bit accumulator. Each operation names an 8-bit bit address. The block turns that address into a byte address and a bit position for the surrounding data path. The caller reads that byte and hands it back in the same cycle, together with the current carry value and an operation code.

One clock later the block presents its results:
- the new carry value;
- a byte write-back in which only the addressed bit may differ from the byte that was read;
- a taken flag for the conditional jumps.

Storage and program-counter arithmetic stay with the caller.

The bit space is split in two halves. The low half, bit addresses 0x00–0x7F, covers a 16-byte RAM window at byte addresses 0x20–0x2F. Bit address 0x00 is bit 0 of byte 0x20. The high half, 0x80–0xFF, covers byte registers. Only registers whose byte address has a low hex digit of 0 or 8 carry addressable bits.

Top module: `bitproc_core`

## Requirements
- R1: A bit address with bit 7 clear maps to byte address 0x20 + addr[6:3] and bit position addr[2:0]; `reg_space` is 0.
- R2: A bit address with bit 7 set maps to byte address {addr[7:3],3'b000}, so the low hex digit is always 0 or 8, and to bit position addr[2:0]; `reg_space` is 1.
- R3: Operation codes 1–4 set carry to carry AND bit, carry AND NOT bit, carry OR bit and carry OR NOT bit, in that order.
- R4: Code 5 copies the bit into carry. Code 6 writes carry into the bit, with `wr_en` 1 and `wr_data` equal to the read byte with that bit replaced.
- R5: Codes 7, 8 and 9 clear, set and complement carry, with no write-back.
- R6: Codes 10, 11 and 12 clear, set and complement the addressed bit. `wr_en` is 1, and the other seven bits of `wr_data` equal the read byte.
- R7: Code 13 reports taken when carry is 1. Code 14 reports taken when carry is 0.
- R8: Code 15 reports taken when the bit is 1. Code 16 reports taken when the bit is 0. Neither writes.
- R9: Code 17 reports taken when the bit is 1 and then writes the byte with that bit cleared. When the bit is 0 it reports not taken and `wr_en` stays 0.
- R10: `wr_en` is 1 only for codes 6, 10, 11, 12 and a taken 17. Every code other than 1–5 and 7–9 returns the incoming carry unchanged, and codes 0 and 18–31 do nothing.
- R11: The results appear on the clock edge after `op_valid`, with `res_valid` 1. A cycle without `op_valid` gives `res_valid`, `wr_en` and `taken` all 0.
- R12: While `rst_n` is low at a clock edge, `res_valid`, `carry_out`, `wr_en`, `wr_data` and `taken` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Operation code, encoded as listed in the requirements |
| bit_addr | input | 8 | Bit address |
| carry_in | input | 1 | Current carry flag |
| rd_byte | input | 8 | Contents of the byte at `byte_addr` |
| byte_addr | output | 8 | Byte address derived from `bit_addr` (combinational) |
| bit_pos | output | 3 | Bit position derived from `bit_addr` (combinational) |
| reg_space | output | 1 | 1 when the bit lies in the register half |
| res_valid | output | 1 | Results below belong to the previous cycle's operation |
| carry_out | output | 1 | New carry flag |
| wr_en | output | 1 | Write `wr_data` back to the byte |
| wr_data | output | 8 | Byte to write back |
| taken | output | 1 | Conditional jump taken |

## Verification
The case hardest to reach from the ports is the test-and-clear jump. It has to be shown that it writes a cleared bit only when it jumps. It must also be shown that the other seven bits survive, and that a non-taken test leaves `wr_en` low.

To cover this, the stimulus runs code 17 with several read bytes:
- the addressed bit set and the neighbouring bits clear;
- the addressed bit set and a neighbouring bit set;
- every bit set except the addressed one.

The address boundaries 0x00, 0x7F, 0x80 and 0xFF exercise the two halves of the bit space and where they meet.

// File: rtl/bitproc_pkg.sv
// Package: shared operation encoding and widths for the bit processor.
// Assumes: op codes outside the enumerated list behave as no-operation.
package bitproc_pkg;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int POS_W   = $clog2(DATA_W);
    localparam int OP_W    = 5;
    localparam int WIN_BASE = 8'h20;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 5'd0,
        OP_ANDC  = 5'd1,
        OP_ANDNC = 5'd2,
        OP_ORC   = 5'd3,
        OP_ORNC  = 5'd4,
        OP_LDC   = 5'd5,
        OP_STC   = 5'd6,
        OP_CLRC  = 5'd7,
        OP_SETC  = 5'd8,
        OP_CPLC  = 5'd9,
        OP_CLRB  = 5'd10,
        OP_SETB  = 5'd11,
        OP_CPLB  = 5'd12,
        OP_JC    = 5'd13,
        OP_JNC   = 5'd14,
        OP_JB    = 5'd15,
        OP_JNB   = 5'd16,
        OP_JBC   = 5'd17
    } bit_op_e;

    // True for the codes that branch on a condition.
    function automatic logic is_jump(input logic [OP_W-1:0] op);
        return (op >= OP_JC) && (op <= OP_JBC);
    endfunction
endpackage

// File: rtl/bitproc_addr_map.sv
// Module: splits a bit address into byte address, bit position and a
// one-hot bit mask. The low half lands in a 16-byte RAM window and the
// high half in registers whose address ends in 0 or 8.
// Assumes: ADDR_W is 8 and DATA_W is 8 (one bit address per bit of a byte).
module bitproc_addr_map
    import bitproc_pkg::*;
(
    input  logic [ADDR_W-1:0] bit_addr,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [POS_W-1:0]  bit_pos,
    output logic [DATA_W-1:0] bit_mask,
    output logic              reg_space
);
    localparam int IDX_W = ADDR_W - POS_W - 1;

    // Selects the byte: window offset in the low half, aligned register above.
    always_comb begin
        reg_space = bit_addr[ADDR_W-1];
        bit_pos   = bit_addr[POS_W-1:0];
        if (reg_space)
            byte_addr = {bit_addr[ADDR_W-1:POS_W], {POS_W{1'b0}}};
        else
            byte_addr = ADDR_W'(WIN_BASE) +
                        ADDR_W'(bit_addr[POS_W+IDX_W-1:POS_W]);
    end

    // One decoder leg per bit of the byte builds the one-hot mask.
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign bit_mask[g] = (bit_pos == POS_W'(g));
    end
endmodule

// File: rtl/bitproc_alu.sv
// Module: combinational evaluation of one bit operation.
// Assumes: rd_byte is the byte selected by the mask for this cycle.
module bitproc_alu
    import bitproc_pkg::*;
(
    input  logic [OP_W-1:0]   op_code,
    input  logic              carry_in,
    input  logic [DATA_W-1:0] rd_byte,
    input  logic [DATA_W-1:0] bit_mask,
    output logic              carry_nx,
    output logic              wr_en_nx,
    output logic [DATA_W-1:0] wr_data_nx,
    output logic              taken_nx
);
    logic bit_val;

    // Extracts the addressed bit through the one-hot mask.
    assign bit_val = |(rd_byte & bit_mask);

    // Computes the new carry, the write-back byte and the branch decision.
    always_comb begin
        carry_nx   = carry_in;
        wr_en_nx   = 1'b0;
        wr_data_nx = rd_byte;
        taken_nx   = 1'b0;
        case (op_code)
            OP_ANDC:  carry_nx = carry_in & bit_val;
            OP_ANDNC: carry_nx = carry_in & ~bit_val;
            OP_ORC:   carry_nx = carry_in | bit_val;
            OP_ORNC:  carry_nx = carry_in | ~bit_val;
            OP_LDC:   carry_nx = bit_val;
            OP_CLRC:  carry_nx = 1'b0;
            OP_SETC:  carry_nx = 1'b1;
            OP_CPLC:  carry_nx = ~carry_in;
            OP_STC: begin
                wr_en_nx   = 1'b1;
                wr_data_nx = carry_in ? (rd_byte | bit_mask) : (rd_byte & ~bit_mask);
            end
            OP_CLRB: begin
                wr_en_nx   = 1'b1;
                wr_data_nx = rd_byte & ~bit_mask;
            end
            OP_SETB: begin
                wr_en_nx   = 1'b1;
                wr_data_nx = rd_byte | bit_mask;
            end
            OP_CPLB: begin
                wr_en_nx   = 1'b1;
                wr_data_nx = rd_byte ^ bit_mask;
            end
            OP_JC:  taken_nx = carry_in;
            OP_JNC: taken_nx = ~carry_in;
            OP_JB:  taken_nx = bit_val;
            OP_JNB: taken_nx = ~bit_val;
            OP_JBC: begin
                taken_nx   = bit_val;
                wr_en_nx   = bit_val;
                wr_data_nx = rd_byte & ~bit_mask;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bitproc_core.sv
// Module: top of the single-bit processor. Maps the address combinationally
// and registers the carry, write-back and branch results one cycle later.
// Assumes: the caller supplies rd_byte from byte_addr in the same cycle and
// applies wr_data/carry_out on the cycle res_valid is high.
module bitproc_core
    import bitproc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [4:0]        op_code,
    input  logic [7:0]        bit_addr,
    input  logic              carry_in,
    input  logic [7:0]        rd_byte,
    output logic [7:0]        byte_addr,
    output logic [2:0]        bit_pos,
    output logic              reg_space,
    output logic              res_valid,
    output logic              carry_out,
    output logic              wr_en,
    output logic [7:0]        wr_data,
    output logic              taken
);
    logic [DATA_W-1:0] bit_mask;
    logic              carry_nx;
    logic              wr_en_nx;
    logic [DATA_W-1:0] wr_data_nx;
    logic              taken_nx;

    bitproc_addr_map u_map (
        .bit_addr  (bit_addr),
        .byte_addr (byte_addr),
        .bit_pos   (bit_pos),
        .bit_mask  (bit_mask),
        .reg_space (reg_space)
    );

    bitproc_alu u_alu (
        .op_code    (op_code),
        .carry_in   (carry_in),
        .rd_byte    (rd_byte),
        .bit_mask   (bit_mask),
        .carry_nx   (carry_nx),
        .wr_en_nx   (wr_en_nx),
        .wr_data_nx (wr_data_nx),
        .taken_nx   (taken_nx)
    );

    // Registers the results of a valid operation; idles the strobes otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            carry_out <= 1'b0;
            wr_en     <= 1'b0;
            wr_data   <= '0;
            taken     <= 1'b0;
        end else if (op_valid) begin
            res_valid <= 1'b1;
            carry_out <= carry_nx;
            wr_en     <= wr_en_nx;
            wr_data   <= wr_data_nx;
            taken     <= taken_nx;
        end else begin
            res_valid <= 1'b0;
            wr_en     <= 1'b0;
            taken     <= 1'b0;
        end
    end

    AST_RAM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_addr[7] |-> (byte_addr[7:4] == 4'h2) && !reg_space) else $error("window"); // R1
    AST_REG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        bit_addr[7] |-> (byte_addr[2:0] == 3'd0) && byte_addr[7]) else $error("align"); // R2
    AST_WR_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !wr_en || ($countones(wr_data ^ $past(rd_byte)) <= 1)) else $error("onebit"); // R6
    AST_JBC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_JBC) |=> (taken == wr_en) && ((wr_data & $past(bit_mask)) == 8'h00)) else $error("jbc"); // R9
    AST_NOTTAKEN_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_jump(op_code)) |=> (taken || !wr_en)) else $error("nowr"); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid && !wr_en && !taken) else $error("idle"); // R11
    AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> res_valid) else $error("wrv"); // R10
endmodule

// File: tb/bitproc_core_tb.sv
// Bench: walks a table of operation vectors, then directed address, idle
// and reset checks.
module bitproc_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [4:0] op_code;
    logic [7:0] bit_addr;
    logic       carry_in;
    logic [7:0] rd_byte;
    logic [7:0] byte_addr;
    logic [2:0] bit_pos;
    logic       reg_space;
    logic       res_valid, carry_out, wr_en, taken;
    logic [7:0] wr_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bitproc_core dut_i (.*);

    // {op, addr, cin, rd, exp_carry, exp_we, exp_wd, exp_taken}
    localparam int NV = 24;
    localparam logic [32:0] VEC [0:NV-1] = '{
        {5'd1,  8'h03, 1'b1, 8'h08, 1'b1, 1'b0, 8'h00, 1'b0},
        {5'd1,  8'h03, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0},
        {5'd2,  8'h03, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0},
        {5'd3,  8'h7F, 1'b0, 8'h80, 1'b1, 1'b0, 8'h00, 1'b0},
        {5'd4,  8'h7F, 1'b0, 8'h80, 1'b0, 1'b0, 8'h00, 1'b0},
        {5'd4,  8'h7F, 1'b0, 8'h7F, 1'b1, 1'b0, 8'h00, 1'b0},
        {5'd5,  8'h81, 1'b0, 8'h02, 1'b1, 1'b0, 8'h00, 1'b0},
        {5'd6,  8'h85, 1'b1, 8'h00, 1'b1, 1'b1, 8'h20, 1'b0},
        {5'd6,  8'h85, 1'b0, 8'hFF, 1'b0, 1'b1, 8'hDF, 1'b0},
        {5'd7,  8'h00, 1'b1, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b0},
        {5'd8,  8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0},
        {5'd9,  8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0},
        {5'd10, 8'h0A, 1'b1, 8'hFF, 1'b1, 1'b1, 8'hFB, 1'b0},
        {5'd11, 8'h0A, 1'b0, 8'h00, 1'b0, 1'b1, 8'h04, 1'b0},
        {5'd12, 8'hE7, 1'b0, 8'hA5, 1'b0, 1'b1, 8'h25, 1'b0},
        {5'd13, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1},
        {5'd14, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0},
        {5'd15, 8'h10, 1'b0, 8'h01, 1'b0, 1'b0, 8'h00, 1'b1},
        {5'd16, 8'h10, 1'b0, 8'h01, 1'b0, 1'b0, 8'h00, 1'b0},
        {5'd17, 8'h16, 1'b0, 8'h40, 1'b0, 1'b1, 8'h00, 1'b1},
        {5'd17, 8'h16, 1'b1, 8'hC0, 1'b1, 1'b1, 8'h80, 1'b1},
        {5'd17, 8'h16, 1'b0, 8'hBF, 1'b0, 1'b0, 8'h00, 1'b0},
        {5'd31, 8'h16, 1'b1, 8'hFF, 1'b1, 1'b0, 8'h00, 1'b0},
        {5'd0,  8'h16, 1'b0, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Tag for a table row, by operation code.
    function automatic string tag_of(input logic [4:0] op);
        if (op >= 5'd1 && op <= 5'd4) return "R3";
        if (op == 5'd5 || op == 5'd6) return "R4";
        if (op >= 5'd7 && op <= 5'd9) return "R5";
        if (op >= 5'd10 && op <= 5'd12) return "R6";
        if (op == 5'd13 || op == 5'd14) return "R7";
        if (op == 5'd15 || op == 5'd16) return "R8";
        if (op == 5'd17) return "R9";
        return "R10";
    endfunction

    task automatic addr_check(input logic [7:0] a, input logic [7:0] eb,
                              input logic [2:0] ep, input logic er, input string tag);
        @(negedge clk);
        bit_addr = a;
        #1;
        check({tag, " byte"}, 32'(byte_addr), 32'(eb));
        check({tag, " pos"}, 32'(bit_pos), 32'(ep));
        check({tag, " half"}, 32'(reg_space), 32'(er));
    endtask

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_code = '0; bit_addr = '0;
        carry_in = 1'b0; rd_byte = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12 reset state
        check("R12 res_valid", 32'(res_valid), 0);
        check("R12 carry", 32'(carry_out), 0);
        check("R12 wr_en", 32'(wr_en), 0);
        check("R12 wr_data", 32'(wr_data), 0);
        check("R12 taken", 32'(taken), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [32:0] v;
            string t;
            v = VEC[i];
            t = tag_of(v[32:28]);
            op_valid = 1'b1;
            op_code  = v[32:28];
            bit_addr = v[27:20];
            carry_in = v[19];
            rd_byte  = v[18:11];
            @(negedge clk);
            check({t, " R11 valid"}, 32'(res_valid), 1);
            check({t, " carry"}, 32'(carry_out), 32'(v[10]));
            check({t, " wr_en"}, 32'(wr_en), 32'(v[9]));
            if (v[9]) check({t, " wr_data"}, 32'(wr_data), 32'(v[8:1]));
            check({t, " taken"}, 32'(taken), 32'(v[0]));
        end

        // R11: idle cycle after a write-producing operation
        op_valid = 1'b1; op_code = 5'd11; bit_addr = 8'h20; rd_byte = 8'h00; carry_in = 1'b1;
        @(negedge clk);
        op_valid = 1'b0; op_code = 5'd13;
        @(negedge clk);
        check("R11 idle valid", 32'(res_valid), 0);
        check("R11 idle wr_en", 32'(wr_en), 0);
        check("R11 idle taken", 32'(taken), 0);

        // R1 / R2 address mapping at the boundaries
        addr_check(8'h00, 8'h20, 3'd0, 1'b0, "R1");
        addr_check(8'h7F, 8'h2F, 3'd7, 1'b0, "R1");
        addr_check(8'h4B, 8'h29, 3'd3, 1'b0, "R1");
        addr_check(8'h80, 8'h80, 3'd0, 1'b1, "R2");
        addr_check(8'hFF, 8'hF8, 3'd7, 1'b1, "R2");
        addr_check(8'hD2, 8'hD0, 3'd2, 1'b1, "R2");

        // R12 reset clears results of a pending operation
        op_valid = 1'b1; op_code = 5'd8; carry_in = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 reset carry", 32'(carry_out), 0);
        check("R12 reset valid", 32'(res_valid), 0);
        rst_n = 1'b1; op_valid = 1'b0;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule